// File: doc/BRIEF.md
# Host Serial Command Port with Queued Bus Master

This block lets a host computer drive a 32-bit on-chip bus over a four-wire serial link. The host acts as an SPI master in mode 0. Each chip-select frame carries one command: an opcode byte, then zero or more 32-bit words sent most significant byte first. Configuration, start address, read length, write data and controller-reset words all enter a single tagged transmit queue.

A small bus master drains that queue strictly in arrival order. It performs writes at the current address and fills a receive queue with read results, which the host then streams back out. Everything runs on the system clock. The serial clock, select and data pins are oversampled through two-stage synchronizers, so the serial clock must be several times slower than the system clock.

Host access to the bus is granted by a configuration bit. While that bit is clear, queued words are still consumed, but the bus is never requested, and reads return zero words.

Top module: `hcmd_host_if`

## Requirements
- R1: A frame starts when `spi_cs_n` falls and ends when it rises. Data is sent MSB first. MOSI is sampled at rising SCK edges, and MISO changes only after falling SCK edges. A word cut short by the select rising is discarded.
- R2: Opcode 0x00 returns the status word. Bits 31:24 = 0xAA, bit 23 = increment setting, bit 22 = host access setting, bits 21:11 = transmit queue occupancy, bits 10:0 = receive queue occupancy. After reset it reads 0xAA00_0000.
- R3: Opcode 0x10 queues one configuration word. Bit 1 enables address increment and bit 0 grants host bus access. The grant is visible on `host_owns_bus`.
- R4: Opcode 0x20 queues one start address, assembled big-endian: bytes 10 34 56 78 give 0x1034_5678.
- R5: Opcode 0x30 queues a read length. Bits 23:0 hold the word count minus one, and that many words are read into the receive queue.
- R6: Opcode 0x40 streams any number of data words, each becoming one bus write. With increment on, the address grows by 4 per access (wrapping modulo 2^32), for both reads and writes. With increment off, every access uses the same address.
- R7: Without host access, `bus_req` stays low, data words are consumed, and each read places 0 in the receive queue.
- R8: Opcode 0x50 streams receive words out MSB first. Reading an empty queue yields 0 and does not advance the read pointer.
- R9: A word pushed into a full transmit queue is dropped and sets `cmd_overflow`, which stays set until the transmit queue is flushed.
- R10: Opcode 0xFD empties the transmit queue, 0xFE empties the receive queue, and 0xFF empties both and ignores the rest of the frame.
- R11: Opcode 0xFC queues a controller-reset word which, in its turn, clears the increment setting, the host grant and the address to 0.
- R12: Queued words take effect in arrival order. An unknown opcode makes the rest of its frame ignored.
- R13: `bus_req` stays high with stable `bus_addr`, `bus_we` and `bus_wdata` until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access completion |
| host_owns_bus | output | 1 | Host access grant setting |
| cmd_overflow | output | 1 | Sticky transmit-queue overflow |

## Verification
Embedded properties watch every cycle for several rules. They check that the bus handshake stays stable while waiting, that no request appears without the host grant, and that the address does not move during an access when increment is off. They also cover queue bounds, dropped and empty-pop behaviour, stickiness of the overflow flag, and silence of a frame once it is being skipped. Only the bench scenarios can show that complete frames decode into the right bus traffic. That covers big-endian word assembly, address stepping and wraparound, ordering across mixed commands, status field contents, flush effects and the zero returned from an empty queue.

// File: rtl/hcmd_pkg.sv
package hcmd_pkg;

  typedef enum logic [2:0] {
    K_CFG  = 3'd0,
    K_ADDR = 3'd1,
    K_RLEN = 3'd2,
    K_DATA = 3'd3,
    K_BRST = 3'd4
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [31:0] word;
  } txent_t;

  typedef enum logic [2:0] {S_OPC, S_STAT, S_PUSH, S_PULL, S_SKIP} spi_st_e;
  typedef enum logic [1:0] {B_IDLE, B_WR, B_RD} bus_st_e;

  localparam logic [7:0] OP_STATUS   = 8'h00;
  localparam logic [7:0] OP_CFG      = 8'h10;
  localparam logic [7:0] OP_ADDR     = 8'h20;
  localparam logic [7:0] OP_RLEN     = 8'h30;
  localparam logic [7:0] OP_WRITE    = 8'h40;
  localparam logic [7:0] OP_READ     = 8'h50;
  localparam logic [7:0] OP_BRST     = 8'hFC;
  localparam logic [7:0] OP_FLUSH_TX = 8'hFD;
  localparam logic [7:0] OP_FLUSH_RX = 8'hFE;
  localparam logic [7:0] OP_RESET    = 8'hFF;
  localparam logic [7:0] STATUS_ID   = 8'hAA;

  function automatic logic [31:0] step_addr(input logic [31:0] a, input logic inc);
    return a + (inc ? 32'd4 : 32'd0);
  endfunction

  function automatic logic [31:0] pack_status(input logic inc, input logic host,
                                              input logic [10:0] txc, input logic [10:0] rxc);
    return {STATUS_ID, inc, host, txc, rxc};
  endfunction

endpackage

// File: rtl/hcmd_fifo.sv
module hcmd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign drop    = push && full && !flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: ;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R9
  AST_FIFO_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop && !flush |=> count == $past(count)); // R9
  AST_FIFO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push && !flush |=> empty); // R8

endmodule

// File: rtl/hcmd_spi_sync.sv
module hcmd_spi_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic mosi_bit
);
  logic [2:0] sck_sh;
  logic [1:0] cs_sh, mosi_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sh  <= '0;
      cs_sh   <= '1;
      mosi_sh <= '0;
    end else begin
      sck_sh  <= {sck_sh[1:0], spi_sck};
      cs_sh   <= {cs_sh[0], spi_cs_n};
      mosi_sh <= {mosi_sh[0], spi_mosi};
    end
  end

  assign sck_rise = sck_sh[1] && !sck_sh[2];
  assign sck_fall = !sck_sh[1] && sck_sh[2];
  assign sel      = !cs_sh[1];
  assign mosi_bit = mosi_sh[1];

endmodule

// File: rtl/hcmd_bus_master.sv
module hcmd_bus_master
  import hcmd_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_empty,
  input  txent_t      tx_head,
  output logic        tx_pop,
  input  logic        rx_full,
  output logic        rx_push,
  output logic [31:0] rx_din,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_ack,
  output logic        incr,
  output logic        host_en
);
  bus_st_e          bst;
  logic [31:0]      addr, wdata;
  logic [LEN_W-1:0] left;
  logic             rd_step;

  assign tx_pop    = (bst == B_IDLE) && !tx_empty;
  assign rd_step   = (bst == B_RD) && !rx_full && (!host_en || bus_ack);
  assign rx_push   = rd_step;
  assign rx_din    = host_en ? bus_rdata : 32'd0;
  assign bus_req   = (bst == B_WR) || ((bst == B_RD) && host_en && !rx_full);
  assign bus_we    = (bst == B_WR);
  assign bus_addr  = addr;
  assign bus_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst     <= B_IDLE;
      addr    <= '0;
      wdata   <= '0;
      left    <= '0;
      incr    <= 1'b0;
      host_en <= 1'b0;
    end else begin
      case (bst)
        B_IDLE: if (!tx_empty) begin
          case (tx_head.kind)
            K_CFG: begin
              incr    <= tx_head.word[1];
              host_en <= tx_head.word[0];
            end
            K_ADDR: addr <= tx_head.word;
            K_RLEN: begin
              left <= tx_head.word[LEN_W-1:0];
              bst  <= B_RD;
            end
            K_DATA: begin
              wdata <= tx_head.word;
              if (host_en) bst <= B_WR;
              else         addr <= step_addr(addr, incr);
            end
            K_BRST: begin
              incr    <= 1'b0;
              host_en <= 1'b0;
              addr    <= '0;
            end
            default: ;
          endcase
        end
        B_WR: if (bus_ack) begin
          addr <= step_addr(addr, incr);
          bst  <= B_IDLE;
        end
        B_RD: if (rd_step) begin
          addr <= step_addr(addr, incr);
          if (left == '0) bst  <= B_IDLE;
          else            left <= left - LEN_W'(1);
        end
        default: bst <= B_IDLE;
      endcase
    end
  end

  AST_REQ_NEEDS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> host_en); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R13
  AST_NO_INCR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bst != B_IDLE) && !incr |=> $stable(bus_addr)); // R6

endmodule

// File: rtl/hcmd_host_if.sv
module hcmd_host_if
  import hcmd_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int LEN_W    = 24,
  localparam int TX_CW   = $clog2(TX_DEPTH + 1),
  localparam int RX_CW   = $clog2(RX_DEPTH + 1),
  localparam int TX_W    = $bits(txent_t)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_ack,
  output logic        host_owns_bus,
  output logic        cmd_overflow
);
  logic sck_rise, sck_fall, sel, mosi_bit;

  hcmd_spi_sync i_sync (
    .clk, .rst_n, .spi_sck, .spi_cs_n, .spi_mosi,
    .sck_rise, .sck_fall, .sel, .mosi_bit
  );

  spi_st_e     st;
  logic [4:0]  bitcnt;
  logic [30:0] shin;
  logic [31:0] rx_word, out_word, status_w, pull_w;
  kind_e       push_kind;
  logic        out_valid, miso_q;
  logic        tx_push_q, rx_pop_q, flush_tx_q, flush_rx_q;
  txent_t      tx_din_q, tx_head;
  logic        tx_empty, tx_full, tx_pop, tx_drop;
  logic [TX_CW-1:0] tx_cnt;
  logic        rx_empty, rx_full, rx_push, rx_drop;
  logic [31:0] rx_din, rx_dout;
  logic [RX_CW-1:0] rx_cnt;
  logic        incr;
  logic        word_end;

  assign rx_word  = {shin, mosi_bit};
  assign word_end = sck_rise && (bitcnt == 5'd31);
  assign status_w = pack_status(incr, host_owns_bus, 11'(tx_cnt), 11'(rx_cnt));
  assign pull_w   = rx_empty ? 32'd0 : rx_dout;
  assign spi_miso = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OPC; bitcnt <= '0; shin <= '0; push_kind <= K_CFG;
      out_word <= '0; out_valid <= 1'b0; miso_q <= 1'b0;
      tx_push_q <= 1'b0; tx_din_q <= '0; rx_pop_q <= 1'b0;
      flush_tx_q <= 1'b0; flush_rx_q <= 1'b0;
    end else begin
      tx_push_q  <= 1'b0;
      rx_pop_q   <= 1'b0;
      flush_tx_q <= 1'b0;
      flush_rx_q <= 1'b0;
      if (!sel) begin
        st     <= S_OPC;
        bitcnt <= '0;
        miso_q <= 1'b0;
      end else begin
        if (sck_rise) begin
          shin <= rx_word[30:0];
          if (st == S_OPC) begin
            if (bitcnt == 5'd7) begin
              bitcnt <= '0;
              case (rx_word[7:0])
                OP_STATUS:   st <= S_STAT;
                OP_CFG:      begin st <= S_PUSH; push_kind <= K_CFG;  end
                OP_ADDR:     begin st <= S_PUSH; push_kind <= K_ADDR; end
                OP_RLEN:     begin st <= S_PUSH; push_kind <= K_RLEN; end
                OP_WRITE:    begin st <= S_PUSH; push_kind <= K_DATA; end
                OP_BRST:     begin st <= S_PUSH; push_kind <= K_BRST; end
                OP_READ:     st <= S_PULL;
                OP_FLUSH_TX: begin st <= S_SKIP; flush_tx_q <= 1'b1; end
                OP_FLUSH_RX: begin st <= S_SKIP; flush_rx_q <= 1'b1; end
                OP_RESET:    begin st <= S_SKIP; flush_tx_q <= 1'b1; flush_rx_q <= 1'b1; end
                default:     st <= S_SKIP;
              endcase
            end else begin
              bitcnt <= bitcnt + 5'd1;
            end
          end else begin
            bitcnt <= bitcnt + 5'd1;
          end
          if (word_end) begin
            case (st)
              S_PUSH: begin
                tx_push_q     <= 1'b1;
                tx_din_q.kind <= push_kind;
                tx_din_q.word <= rx_word;
                if (push_kind != K_DATA) st <= S_SKIP;
              end
              S_PULL:  rx_pop_q <= out_valid;
              S_STAT:  st <= S_SKIP;
              default: ;
            endcase
          end
        end
        if (sck_fall) begin
          if ((st == S_STAT || st == S_PULL) && bitcnt == 5'd0) begin
            out_word  <= (st == S_STAT) ? status_w : pull_w;
            miso_q    <= (st == S_STAT) ? status_w[31] : pull_w[31];
            out_valid <= (st == S_PULL) && !rx_empty;
          end else if (st == S_STAT || st == S_PULL) begin
            miso_q <= out_word[5'd31 - bitcnt];
          end else begin
            miso_q <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cmd_overflow <= 1'b0;
    else if (flush_tx_q) cmd_overflow <= 1'b0;
    else if (tx_drop)    cmd_overflow <= 1'b1;
  end

  hcmd_fifo #(.W(TX_W), .DEPTH(TX_DEPTH)) i_txq (
    .clk, .rst_n, .flush(flush_tx_q), .push(tx_push_q), .din(tx_din_q),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full),
    .count(tx_cnt), .drop(tx_drop)
  );

  hcmd_fifo #(.W(32), .DEPTH(RX_DEPTH)) i_rxq (
    .clk, .rst_n, .flush(flush_rx_q), .push(rx_push), .din(rx_din),
    .pop(rx_pop_q), .dout(rx_dout), .empty(rx_empty), .full(rx_full),
    .count(rx_cnt), .drop(rx_drop)
  );

  hcmd_bus_master #(.LEN_W(LEN_W)) i_bm (
    .clk, .rst_n, .tx_empty, .tx_head, .tx_pop,
    .rx_full, .rx_push, .rx_din,
    .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .bus_ack,
    .incr, .host_en(host_owns_bus)
  );

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_overflow && !flush_tx_q |=> cmd_overflow); // R9
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop && !flush_tx_q |=> cmd_overflow); // R9
  AST_RX_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_drop); // R5
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SKIP |=> !tx_push_q && !rx_pop_q); // R12
  AST_IDLE_TX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_empty); // R9

endmodule

// File: tb/test_hcmd_host_if.sv
module test_hcmd_host_if;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, spi_miso;
  logic bus_req, bus_we, bus_ack = 1'b0, host_owns_bus, cmd_overflow;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic ack_en = 1'b1;

  int checks = 0, fails = 0, req_cycles = 0, wlog_n = 0;
  logic [31:0] wlog_addr [64];
  logic [31:0] wlog_data [64];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcmd_host_if i_hcmd_host_if (
    .clk, .rst_n, .spi_sck, .spi_cs_n, .spi_mosi, .spi_miso,
    .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .bus_ack,
    .host_owns_bus, .cmd_overflow
  );

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  assign bus_rdata = model_rd(bus_addr);

  always @(posedge clk) begin
    bus_ack <= bus_req && !bus_ack && ack_en;
    if (bus_req) req_cycles <= req_cycles + 1;
    if (bus_req && bus_ack && bus_we) begin
      wlog_addr[wlog_n[5:0]] <= bus_addr;
      wlog_data[wlog_n[5:0]] <= bus_wdata;
      wlog_n <= wlog_n + 1;
    end
  end

  // {incr, count, start address, first data word}
  localparam logic [68:0] VEC [3] = '{
    {1'b1, 4'd4, 32'h1034_5678, 32'hDEAD_BEEF},
    {1'b0, 4'd3, 32'h0000_0200, 32'h0102_0304},
    {1'b1, 4'd5, 32'hFFFF_FFF8, 32'h5555_0000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      rx[i] = spi_miso;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xword(input logic [31:0] tx, output logic [31:0] rx);
    logic [7:0] b;
    for (int k = 3; k >= 0; k--) begin
      xbyte(tx[k*8 +: 8], b);
      rx[k*8 +: 8] = b;
    end
  endtask

  task automatic cmd1(input logic [7:0] op, input logic [31:0] w);
    logic [7:0] j; logic [31:0] r;
    cs_lo(); xbyte(op, j); xword(w, r); cs_hi();
  endtask

  task automatic cmd0(input logic [7:0] op);
    logic [7:0] j;
    cs_lo(); xbyte(op, j); cs_hi();
  endtask

  task automatic get_status(output logic [31:0] s);
    logic [7:0] j;
    cs_lo(); xbyte(8'h00, j); xword(32'h0, s); cs_hi();
  endtask

  task automatic drain();
    repeat (60) @(negedge clk);
  endtask

  logic [31:0] st, rw, a;
  logic [7:0]  jb;
  int base, reqs0;

  initial begin
    repeat (HALF * 200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Reset state
    check(spi_miso == 0 && bus_req == 0, "R13 reset idle", {30'd0, spi_miso, bus_req}, 32'h0);
    check(host_owns_bus == 0 && cmd_overflow == 0, "R3 reset flags", {30'd0, host_owns_bus, cmd_overflow}, 32'h0);
    get_status(st);
    check(st == 32'hAA00_0000, "R2 reset status MSB first R1", st, 32'hAA00_0000);

    // Table of write/read-back patterns
    for (int v = 0; v < 3; v++) begin
      logic inc; int n; logic [31:0] sa, sd;
      inc = VEC[v][68]; n = int'(VEC[v][67:64]); sa = VEC[v][63:32]; sd = VEC[v][31:0];
      base = wlog_n;
      cmd1(8'h10, {30'd0, inc, 1'b1});
      check(host_owns_bus == 1, "R3 grant", {31'd0, host_owns_bus}, 32'h1);
      cmd1(8'h20, sa);
      cs_lo(); xbyte(8'h40, jb);
      for (int k = 0; k < n; k++) xword(sd + 32'(k), rw);
      cs_hi();
      drain();
      check(wlog_n - base == n, "R6 write count", 32'(wlog_n - base), 32'(n));
      a = sa;
      for (int k = 0; k < n; k++) begin
        check(wlog_addr[base + k] == a, "R4 R6 write address", wlog_addr[base + k], a);
        check(wlog_data[base + k] == sd + 32'(k), "R6 write data", wlog_data[base + k], sd + 32'(k));
        if (inc) a = a + 32'd4;
      end
      cmd1(8'h30, 32'(n - 1));
      drain();
      get_status(st);
      check(st == {8'hAA, inc, 1'b1, 11'd0, 11'(n)}, "R2 R5 status after read", st, {8'hAA, inc, 1'b1, 11'd0, 11'(n)});
      cs_lo(); xbyte(8'h50, jb);
      for (int k = 0; k < n; k++) begin
        xword(32'h0, rw);
        check(rw == model_rd(a), "R5 R8 read data", rw, model_rd(a));
        if (inc) a = a + 32'd4;
      end
      cs_hi();
    end

    // Host access withheld
    cmd1(8'h10, 32'h2);
    check(host_owns_bus == 0, "R3 release", {31'd0, host_owns_bus}, 32'h0);
    reqs0 = req_cycles; base = wlog_n;
    cs_lo(); xbyte(8'h40, jb); xword(32'h1111_1111, rw); xword(32'h2222_2222, rw); cs_hi();
    cmd1(8'h30, 32'h0000_0002);
    drain();
    check(req_cycles == reqs0 && wlog_n == base, "R7 no bus use", 32'(req_cycles - reqs0), 32'h0);
    get_status(st);
    check(st == {8'hAA, 1'b1, 1'b0, 11'd0, 11'd3}, "R7 dummy words queued", st, {8'hAA, 1'b1, 1'b0, 11'd0, 11'd3});
    cs_lo(); xbyte(8'h50, jb);
    for (int k = 0; k < 4; k++) begin
      xword(32'h0, rw);
      check(rw == 32'h0, "R7 R8 zero word", rw, 32'h0);
    end
    cs_hi();
    // Empty read must not advance the pointer
    cmd1(8'h10, 32'h1);
    cmd1(8'h20, 32'h0000_0040);
    cmd1(8'h30, 32'h0);
    drain();
    cs_lo(); xbyte(8'h50, jb); xword(32'h0, rw); xword(32'h0, rw); cs_hi();
    cs_lo(); xbyte(8'h50, jb); xword(32'h0, rw); cs_hi();
    check(rw == 32'h0, "R8 empty again", rw, 32'h0);
    cmd1(8'h30, 32'h0);
    drain();
    cs_lo(); xbyte(8'h50, jb); xword(32'h0, rw); cs_hi();
    check(rw == model_rd(32'h40), "R8 pointer intact", rw, model_rd(32'h40));

    // Overflow while the bus stalls
    ack_en = 1'b0;
    cmd1(8'h10, 32'h3);
    cmd1(8'h20, 32'h0000_0100);
    base = wlog_n;
    cs_lo(); xbyte(8'h40, jb);
    for (int k = 0; k < 20; k++) xword(32'hA000_0000 + 32'(k), rw);
    cs_hi();
    check(bus_req == 1 && bus_addr == 32'h100 && bus_wdata == 32'hA000_0000, "R13 held request", bus_addr, 32'h100);
    check(cmd_overflow == 1, "R9 overflow set", {31'd0, cmd_overflow}, 32'h1);
    get_status(st);
    check(st[21:11] == 11'd16, "R9 queue full count", {21'd0, st[21:11]}, 32'd16);
    check(cmd_overflow == 1, "R9 sticky", {31'd0, cmd_overflow}, 32'h1);
    cmd0(8'hFD);
    check(cmd_overflow == 0, "R9 R10 cleared by flush", {31'd0, cmd_overflow}, 32'h0);
    get_status(st);
    check(st[21:11] == 11'd0, "R10 tx flushed", {21'd0, st[21:11]}, 32'h0);
    ack_en = 1'b1;
    drain();
    check(wlog_n - base == 1 && wlog_data[base] == 32'hA000_0000, "R13 stalled write lands", wlog_data[base], 32'hA000_0000);

    // Receive flushes
    cmd1(8'h30, 32'h1);
    drain();
    cmd0(8'hFE);
    get_status(st);
    check(st[10:0] == 11'd0, "R10 rx flushed", {21'd0, st[10:0]}, 32'h0);
    cmd1(8'h30, 32'h2);
    drain();
    base = wlog_n;
    cs_lo(); xbyte(8'hFF, jb); xbyte(8'h40, jb); xword(32'h1234_5678, rw); cs_hi();
    drain();
    get_status(st);
    check(st[21:0] == 22'd0 && wlog_n == base, "R10 full reset ignores rest", st, {st[31:22], 22'd0});

    // Unknown opcode and aborted word
    cs_lo(); xbyte(8'h77, jb); xbyte(8'h40, jb); xword(32'hCAFE_F00D, rw); cs_hi();
    cs_lo(); xbyte(8'h40, jb); xbyte(8'h12, jb); xbyte(8'h34, jb); cs_hi();
    drain();
    get_status(st);
    check(st[21:11] == 11'd0 && wlog_n == base, "R12 R1 nothing queued", 32'(wlog_n - base), 32'h0);

    // Ordering of mixed queued words
    cs_lo(); xbyte(8'h20, jb); xword(32'h0000_0300, rw); cs_hi();
    cs_lo(); xbyte(8'h40, jb); xword(32'h0000_00D1, rw); cs_hi();
    cs_lo(); xbyte(8'h20, jb); xword(32'h0000_0500, rw); cs_hi();
    cs_lo(); xbyte(8'h40, jb); xword(32'h0000_00D2, rw); cs_hi();
    drain();
    check(wlog_addr[base] == 32'h300 && wlog_data[base] == 32'hD1, "R12 first in order", wlog_addr[base], 32'h300);
    check(wlog_addr[base+1] == 32'h500 && wlog_data[base+1] == 32'hD2, "R12 second in order", wlog_addr[base+1], 32'h500);

    // Controller reset word
    cmd1(8'hFC, 32'h0);
    drain();
    get_status(st);
    check(st == 32'hAA00_0000 && host_owns_bus == 0, "R11 settings cleared", st, 32'hAA00_0000);
    cmd1(8'h10, 32'h1);
    base = wlog_n;
    cmd1(8'h40, 32'h0000_0055);
    drain();
    check(wlog_n - base == 1 && wlog_addr[base] == 32'h0, "R11 address cleared", wlog_addr[base], 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule